// File: doc/BRIEF.md
# Primary Interrupt Controller with IRQ/FIQ Steering

This block gathers up to 64 level-sensitive interrupt lines from on-chip peripherals and turns them into two requests for the processor core. One is a normal interrupt request (IRQ) and the other is a fast interrupt request (FIQ). Each line has an enable bit and a steering bit. The steering bit picks which of the two requests the line feeds. A third output tells the power controller that the core should leave idle.

Software programs the block through a small register bus. Writes are synchronous, with one write strobe and a byte address. Reads are combinational from the address. The lines are split into a low bank (lines 0–31) and a high bank (lines 32–63). Each bank has its own enable word, steering word and two read-only status words. The controller stores no events. A line stays active for as long as its peripheral holds it high, and it is cleared at that peripheral.

Top module: `pirq_steer_ctrl`

## Requirements
- R1: After reset, the enable words, steering words and control word read zero, and `irq_o`, `fiq_o` and `wake_o` are low.
- R2: The low-bank enable word is at offset 0x00 and the high-bank enable word is at 0x04. Bit n of a bank word belongs to line n (low bank) or line 32+n (high bank). Both words read back what was written.
- R3: An enable bit of 1 lets its line request the core. A bit of 0 keeps that line off both `irq_o` and `fiq_o`.
- R4: The steering words are at 0x08 (low bank) and 0x0C (high bank). A bit of 0 sends its line to `irq_o` and a bit of 1 sends it to `fiq_o`. Both words read back what was written.
- R5: `irq_o`, `fiq_o` and `wake_o` are registered. They reflect the inputs and configuration present before the previous rising clock edge, with exactly one cycle of latency.
- R6: The status words are read-only and writes to them are ignored:
  - 0x14 and 0x18 show active & enabled & IRQ-steered lines for the low and high banks.
  - 0x1C and 0x20 show active & enabled & FIQ-steered lines for the low and high banks.
- R7: The control word is at 0x10. Its bit 0 is the idle-wake filter, and the other bits read zero. With the filter at 1, `wake_o` is raised only by active lines that are enabled.
- R8: With the filter at 0, any active line raises `wake_o`, whether it is enabled or not.
- R9: Lines are level-sensitive. Once every line drops, all three outputs fall after one cycle, and nothing is remembered.
- R10: Addresses outside the map read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt lines from peripherals |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |
| wake_o | output | 1 | Idle wake-up request |

## Verification
A corrupted enable or steering bit shows up in the status words as soon as its line is driven. One cycle later it shows on the wrong request output, or as a request that is missing. A wrong filter bit shows as a wake request from a disabled line, or as a wake request that is missing, one cycle after that line rises. The bench therefore drives random line patterns against random configurations. At each step it compares every readable word and all three outputs with a model built from the register map.

// File: rtl/pirq_steer_ctrl.sv
module pirq_steer_ctrl #(
  parameter int NUM_SRC = 64,
  parameter int AW      = 6,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int NB = 2 * DW;
  localparam logic [AW-1:0] A_EN_LO  = AW'(8'h00);
  localparam logic [AW-1:0] A_EN_HI  = AW'(8'h04);
  localparam logic [AW-1:0] A_LV_LO  = AW'(8'h08);
  localparam logic [AW-1:0] A_LV_HI  = AW'(8'h0C);
  localparam logic [AW-1:0] A_CTRL   = AW'(8'h10);
  localparam logic [AW-1:0] A_IP_LO  = AW'(8'h14);
  localparam logic [AW-1:0] A_IP_HI  = AW'(8'h18);
  localparam logic [AW-1:0] A_FP_LO  = AW'(8'h1C);
  localparam logic [AW-1:0] A_FP_HI  = AW'(8'h20);
  localparam logic [NB-1:0] IMPL     = NB'({NUM_SRC{1'b1}});

  logic [NB-1:0] src_w, mask_q, lvl_q, irq_pend, fiq_pend;
  logic          dim_q;

  assign src_w    = NB'(src_i);
  assign irq_pend = src_w & mask_q & ~lvl_q;
  assign fiq_pend = src_w & mask_q & lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      lvl_q  <= '0;
      dim_q  <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        A_EN_LO: mask_q[DW-1:0]  <= bus_wdata & IMPL[DW-1:0];
        A_EN_HI: mask_q[NB-1:DW] <= bus_wdata & IMPL[NB-1:DW];
        A_LV_LO: lvl_q[DW-1:0]   <= bus_wdata & IMPL[DW-1:0];
        A_LV_HI: lvl_q[NB-1:DW]  <= bus_wdata & IMPL[NB-1:DW];
        A_CTRL:  dim_q           <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_EN_LO: bus_rdata = mask_q[DW-1:0];
      A_EN_HI: bus_rdata = mask_q[NB-1:DW];
      A_LV_LO: bus_rdata = lvl_q[DW-1:0];
      A_LV_HI: bus_rdata = lvl_q[NB-1:DW];
      A_CTRL:  bus_rdata = DW'(dim_q);
      A_IP_LO: bus_rdata = irq_pend[DW-1:0];
      A_IP_HI: bus_rdata = irq_pend[NB-1:DW];
      A_FP_LO: bus_rdata = fiq_pend[DW-1:0];
      A_FP_HI: bus_rdata = fiq_pend[NB-1:DW];
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |irq_pend;
      fiq_o  <= |fiq_pend;
      wake_o <= dim_q ? |(src_w & mask_q) : |src_w;
    end
  end
endmodule

// File: rtl/pirq_steer_chk.sv
module pirq_steer_chk #(
  parameter int NUM_SRC = 64,
  parameter int NB      = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NB-1:0]      mask_q,
  input logic [NB-1:0]      lvl_q,
  input logic               dim_q,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               wake_o
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;

  // R3
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    $past(mask_q == '0) |-> (!irq_o && !fiq_o));

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    $past(src_i == '0) |-> (!irq_o && !fiq_o && !wake_o));

  // R7
  request_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (irq_o || fiq_o) |-> wake_o);

  // R4
  no_fiq_steer_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    $past(lvl_q == '0) |-> !fiq_o);

  // R7
  filter_block_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    ($past(dim_q) && $past((NB'(src_i) & mask_q) == '0)) |-> !wake_o);

  // R8
  open_wake_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (!$past(dim_q) && $past(src_i != '0)) |-> wake_o);
endmodule

bind pirq_steer_ctrl pirq_steer_chk #(.NUM_SRC(NUM_SRC), .NB(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_q(mask_q), .lvl_q(lvl_q),
  .dim_q(dim_q), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
);

// File: tb/tb_pirq_steer_ctrl.sv
module tb_pirq_steer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, wake_o;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m = '0, l = '0;
  logic        d = 1'b0;

  always #4 clk = ~clk;

  pirq_steer_ctrl dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o));

  function automatic logic f_irq(logic [63:0] s, logic [63:0] mk, logic [63:0] lv);
    return |(s & mk & ~lv);
  endfunction
  function automatic logic f_fiq(logic [63:0] s, logic [63:0] mk, logic [63:0] lv);
    return |(s & mk & lv);
  endfunction
  function automatic logic f_wake(logic [63:0] s, logic [63:0] mk, logic dm);
    return dm ? |(s & mk) : |s;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [5:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic config_all(logic [63:0] mk, logic [63:0] lv, logic dm);
    wr(6'h00, mk[31:0]); wr(6'h04, mk[63:32]);
    wr(6'h08, lv[31:0]); wr(6'h0C, lv[63:32]);
    wr(6'h10, {31'(0), dm});
    m = mk; l = lv; d = dm;
  endtask

  task automatic full_check(string tag);
    @(negedge clk);
    rd_check({tag, " R2 en_lo"}, 6'h00, m[31:0]);
    rd_check({tag, " R2 en_hi"}, 6'h04, m[63:32]);
    rd_check({tag, " R4 lv_lo"}, 6'h08, l[31:0]);
    rd_check({tag, " R4 lv_hi"}, 6'h0C, l[63:32]);
    rd_check({tag, " R7 ctrl"}, 6'h10, {31'(0), d});
    rd_check({tag, " R6 ip_lo"}, 6'h14, 32'(src_i & m & ~l));
    rd_check({tag, " R6 ip_hi"}, 6'h18, 32'((src_i & m & ~l) >> 32));
    rd_check({tag, " R6 fp_lo"}, 6'h1C, 32'(src_i & m & l));
    rd_check({tag, " R6 fp_hi"}, 6'h20, 32'((src_i & m & l) >> 32));
    check({tag, " R3 R4 irq"}, 64'(irq_o), 64'(f_irq(src_i, m, l)));
    check({tag, " R3 R4 fiq"}, 64'(fiq_o), 64'(f_fiq(src_i, m, l)));
    check({tag, " R7 R8 wake"}, 64'(wake_o), 64'(f_wake(src_i, m, d)));
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_check("R1 en_lo", 6'h00, 0);
    rd_check("R1 en_hi", 6'h04, 0);
    rd_check("R1 lv_lo", 6'h08, 0);
    rd_check("R1 lv_hi", 6'h0C, 0);
    rd_check("R1 ctrl", 6'h10, 0);
    check("R1 outs", {61'(0), irq_o, fiq_o, wake_o}, 0);
    rst_n = 1'b1;
    full_check("R1 after release");

    // R8: filter off, disabled line still wakes
    src_i = 64'h1 << 40;
    full_check("R8 disabled wake");
    check("R8 wake", 64'(wake_o), 1);
    // R7: filter on blocks disabled line
    config_all(64'h0, 64'h0, 1'b1);
    full_check("R7 filter on");
    check("R7 no wake", 64'(wake_o), 0);

    // R5 latency: IRQ-steered enabled line
    config_all(64'h1 << 40, 64'h0, 1'b1);
    src_i = '0;
    @(negedge clk); @(negedge clk);
    src_i = 64'h1 << 40;
    #1 check("R5 irq before edge", 64'(irq_o), 0);
    @(negedge clk);
    check("R5 irq after one edge", 64'(irq_o), 1);
    check("R5 fiq stays low", 64'(fiq_o), 0);

    // R4: steer same line to FIQ (high bank)
    config_all(64'h1 << 40, 64'h1 << 40, 1'b1);
    full_check("R4 fiq steer");
    check("R4 fiq", 64'(fiq_o), 1);

    // R9: drop lines, outputs fall after one cycle
    src_i = '0;
    #1 check("R9 still high before edge", 64'(fiq_o), 1);
    @(negedge clk);
    check("R9 dropped", {61'(0), irq_o, fiq_o, wake_o}, 0);

    // R6: writes to status words ignored; R10 unmapped
    src_i = 64'h8000_0001_0000_0003;
    config_all(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 1'b0);
    wr(6'h14, 32'h0); wr(6'h18, 32'hFFFF_FFFF); wr(6'h1C, 32'h0); wr(6'h20, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF); wr(6'h02, 32'h0);
    full_check("R6 R10 ignored writes");
    rd_check("R10 unmapped 0x24", 6'h24, 0);
    rd_check("R10 unmapped 0x3C", 6'h3C, 0);
    rd_check("R6 ip_lo direct", 6'h14, 32'h0000_0002);
    rd_check("R6 fp_hi direct", 6'h20, 32'h8000_0000);
    wr(6'h10, 32'hFFFF_FFFE);
    d = 1'b0;
    rd_check("R7 ctrl upper bits zero", 6'h10, 0);

    // random sweep
    for (int i = 0; i < 300; i++) begin
      logic [63:0] mk, lv;
      mk = {$urandom, $urandom};
      lv = {$urandom, $urandom};
      if (i % 5 == 0) mk = '0;
      config_all(mk, lv, 1'($urandom));
      for (int k = 0; k < 3; k++) begin
        src_i = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        if (k == 2 && (i % 3 == 0)) src_i = '0;
        full_check("R3 R6 random");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule